// File: doc/BRIEF.md
# Two-Port Banked Scratchpad with Conflict Serialization

This block is a local scratchpad of 32-bit words spread over 32 banks. Four SIMD units share it. Each cycle, one 16-lane request comes in on port A (issued by SIMD 0 or SIMD 1) and one comes in on port B (issued by SIMD 2 or SIMD 3). The block fuses the two into a single 32-lane access.

Lanes whose addresses fall into distinct banks are served together in one round. The same holds for lanes that read the very same word, which receive it as a broadcast. Lanes that hit one bank at different words are served over extra rounds. During those rounds the block holds `ready` low, so both ports stall, even when only one of them caused the conflict.

When the last lane of an access has been served, `done` pulses for one cycle. The read word of every served lane appears on `rdata` in that same cycle.

Top module: `banked_scratchpad`

## Requirements
- R1: Port A lanes occupy merged lanes 0..15 and port B lanes occupy merged lanes 16..31. A port whose valid is low in the accepting cycle contributes no active lanes.
- R2: The bank of a lane is its word address modulo 32, which is the low 5 address bits. The upper bits select the row. An access whose active lanes all sit in distinct banks completes in one round.
- R3: Active lanes that name the same word are served in one round by broadcast and add no round.
- R4: An access needs K rounds, where K is the largest number of distinct addresses among active lanes of any one bank. In each round, every bank serves the address of its lowest-numbered pending lane, together with every pending lane that names that address. `done` is high for exactly one cycle, right after the K-th rising edge that follows the accepting edge.
- R5: Conflicts are detected across the two ports. For example, an active lane 0 at address 0 and an active lane 16 at address 32 need 2 rounds.
- R6: `ready` is low from the accepting edge until `done` rises, and it is high in the `done` cycle. Requests presented while `ready` is low are ignored and write nothing.
- R7: An inactive lane takes no part in arbitration, writes nothing, and keeps its previous `rdata` word. An accepted access with no active lanes completes with K = 0.
- R8: When several active lanes write one word in the same access, the highest-numbered lane's data is stored.
- R9: Every served lane, including writing lanes, returns the contents the word held before this access. A later access returns the newly written value.
- R10: After reset, `ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Port A request present (SIMD 0/1) |
| a_we | input | 1 | Port A is a write request |
| a_mask | input | 16 | Port A per-lane active mask |
| a_addr | input | 16*9 | Port A per-lane word addresses, lane i at bits [9i+8:9i] |
| a_wdata | input | 16*32 | Port A per-lane write data |
| b_valid | input | 1 | Port B request present (SIMD 2/3) |
| b_we | input | 1 | Port B is a write request |
| b_mask | input | 16 | Port B per-lane active mask |
| b_addr | input | 16*9 | Port B per-lane word addresses |
| b_wdata | input | 16*32 | Port B per-lane write data |
| ready | output | 1 | Both ports may issue; low while a conflict is serialized |
| done | output | 1 | One-cycle pulse when the accepted access is complete |
| rdata | output | 32*32 | Per merged lane read word, lane i at bits [32i+31:32i] |

## Verification
A request is accepted on the rising edge where `ready` is high. `done` and `rdata` become valid right after the K-th edge that follows it, with K = 0 for an empty access. The bench computes K for each access from its own count of distinct addresses per bank, and it keeps a shadow copy of memory. It counts edges from the accepting one, sampling at falling edges, and compares that count with K. At the same point it checks that `ready` stayed low throughout the access and that `done` falls one cycle later. It then compares `rdata` against the shadow copy of memory, and injects a write while the block is stalled to show that the write is dropped.

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES = 16,
  parameter int BANKS = 32,
  parameter int ROWS  = 16,
  parameter int DW    = 32,
  localparam int NL = 2 * LANES,
  localparam int BW = $clog2(BANKS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = BW + RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic              a_we,
  input  logic [LANES-1:0]  a_mask,
  input  logic [LANES*AW-1:0] a_addr,
  input  logic [LANES*DW-1:0] a_wdata,
  input  logic              b_valid,
  input  logic              b_we,
  input  logic [LANES-1:0]  b_mask,
  input  logic [LANES*AW-1:0] b_addr,
  input  logic [LANES*DW-1:0] b_wdata,
  output logic              ready,
  output logic              done,
  output logic [NL*DW-1:0]  rdata
);

  logic [NL-1:0] pend_q, lead, serve, we_q, new_mask;
  logic [AW-1:0] addr_q  [NL];
  logic [DW-1:0] wdata_q [NL];
  logic [DW-1:0] rd_q    [NL];
  logic [DW-1:0] mem     [BANKS*ROWS];
  logic          done_q;
  logic          accept;

  assign ready    = ~|pend_q;
  assign done     = done_q;
  assign accept   = ready && (a_valid || b_valid);
  assign new_mask = {b_valid ? b_mask : '0, a_valid ? a_mask : '0};

  // a lane leads its bank when no lower pending lane shares the bank;
  // every pending lane naming a leader's word rides along (broadcast)
  always_comb begin
    for (int i = 0; i < NL; i++) begin
      lead[i] = pend_q[i];
      for (int j = 0; j < i; j++)
        if (pend_q[j] && addr_q[j][BW-1:0] == addr_q[i][BW-1:0]) lead[i] = 1'b0;
    end
    for (int i = 0; i < NL; i++) begin
      serve[i] = 1'b0;
      for (int j = 0; j <= i; j++)
        if (lead[j] && addr_q[j] == addr_q[i]) serve[i] = 1'b1;
      serve[i] = serve[i] & pend_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pend_q <= new_mask;
        done_q <= ~|new_mask;
      end else if (|pend_q) begin
        pend_q <= pend_q & ~serve;
        done_q <= ~|(pend_q & ~serve);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < LANES; i++) begin
        addr_q[i]          <= a_addr[i*AW +: AW];
        addr_q[i+LANES]    <= b_addr[i*AW +: AW];
        wdata_q[i]         <= a_wdata[i*DW +: DW];
        wdata_q[i+LANES]   <= b_wdata[i*DW +: DW];
        we_q[i]            <= a_we;
        we_q[i+LANES]      <= b_we;
      end
    end
    // ascending loop: the last (highest) writing lane of a word wins
    for (int i = 0; i < NL; i++) begin
      if (serve[i]) begin
        rd_q[i] <= mem[addr_q[i]];
        if (we_q[i]) mem[addr_q[i]] <= wdata_q[i];
      end
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_rd
    assign rdata[g*DW +: DW] = rd_q[g];
  end

  p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $countones(pend_q) < $past($countones(pend_q)));

  p_ready_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  p_stall_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && new_mask != '0) |=> !ready);

  p_fall_needs_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(a_valid || b_valid));

  p_empty_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && new_mask == '0) |=> done);

endmodule

// File: tb/test_banked_scratchpad.sv
module test_banked_scratchpad;
  localparam int CLK_PERIOD = 10;
  localparam int L = 16, NL = 32, DW = 32, AW = 9, WORDS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_valid, a_we, b_valid, b_we, ready, done;
  logic [L-1:0] a_mask, b_mask;
  logic [L*AW-1:0] a_addr, b_addr;
  logic [L*DW-1:0] a_wdata, b_wdata;
  logic [NL*DW-1:0] rdata;

  banked_scratchpad i_banked_scratchpad (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_we(a_we), .a_mask(a_mask), .a_addr(a_addr), .a_wdata(a_wdata),
    .b_valid(b_valid), .b_we(b_we), .b_mask(b_mask), .b_addr(b_addr), .b_wdata(b_wdata),
    .ready(ready), .done(done), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [31:0] model [WORDS];
  logic [31:0] exp_rd [NL];
  int ad [NL];
  bit act [NL];
  logic [31:0] wd [NL];
  bit va, vb, wa, wb;

  task automatic check(bit ok, string req, string what, longint got, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic idle_ports();
    a_valid = 0; b_valid = 0; a_we = 0; b_we = 0;
    a_mask = '0; b_mask = '0; a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
  endtask

  task automatic clear_req();
    va = 0; vb = 0; wa = 0; wb = 0;
    for (int i = 0; i < NL; i++) begin ad[i] = 0; act[i] = 0; wd[i] = '0; end
  endtask

  task automatic drive();
    a_valid = va; b_valid = vb; a_we = wa; b_we = wb;
    for (int i = 0; i < L; i++) begin
      a_mask[i] = act[i];  b_mask[i] = act[i+L];
      a_addr[i*AW +: AW] = ad[i][AW-1:0];  b_addr[i*AW +: AW] = ad[i+L][AW-1:0];
      a_wdata[i*DW +: DW] = wd[i];  b_wdata[i*DW +: DW] = wd[i+L];
    end
  endtask

  function automatic bit eff(int i);
    return act[i] && (i < L ? va : vb);
  endfunction

  function automatic int rounds();
    int cnt [32];
    int k = 0;
    for (int b = 0; b < 32; b++) cnt[b] = 0;
    for (int i = 0; i < NL; i++) begin
      if (eff(i)) begin
        bit first = 1;
        for (int j = 0; j < i; j++) if (eff(j) && ad[j] == ad[i]) first = 0;
        if (first) cnt[ad[i] % 32]++;
      end
    end
    for (int b = 0; b < 32; b++) if (cnt[b] > k) k = cnt[b];
    return k;
  endfunction

  // issue the staged request, count edges to done, check timing and data
  task automatic run(string req, bit chk, bit stall);
    int k = rounds();
    int n = 0;
    bit low_ok = 1;
    int bad = 0, bad_lane = -1;
    for (int i = 0; i < NL; i++) if (eff(i)) exp_rd[i] = model[ad[i]];
    for (int i = 0; i < NL; i++)
      if (eff(i) && (i < L ? wa : wb)) model[ad[i]] = wd[i];
    @(negedge clk);
    check(ready == 1'b1, req, "ready before issue", ready, 1);
    drive();
    @(posedge clk);
    @(negedge clk);
    idle_ports();
    while (!done && n < 100) begin
      if (ready) low_ok = 0;
      if (stall && n == 0) begin
        a_valid = 1; a_we = 1; a_mask = '1;
        for (int i = 0; i < L; i++) begin
          a_addr[i*AW +: AW] = 9'd7; a_wdata[i*DW +: DW] = 32'hDEAD_BEEF;
        end
      end
      @(posedge clk);
      @(negedge clk);
      idle_ports();
      n++;
    end
    check(n == k, req, "rounds to done", n, k);
    check(low_ok && ready, "R6", "ready low while busy, high at done", ready, 1);
    if (chk) begin
      for (int i = 0; i < NL; i++)
        if (rdata[i*DW +: DW] !== exp_rd[i]) begin bad++; bad_lane = i; end
      if (bad_lane >= 0)
        check(0, req, $sformatf("rdata lane %0d", bad_lane),
              rdata[bad_lane*DW +: DW], exp_rd[bad_lane]);
      else check(1, req, "rdata", 0, 0);
    end else begin
      for (int i = 0; i < NL; i++) exp_rd[i] = rdata[i*DW +: DW];
    end
    @(negedge clk);
    check(done == 1'b0, "R4", "done is a single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(ready == 1'b1, "R10", "ready after reset", ready, 1);
    check(done == 1'b0, "R10", "done after reset", done, 0);
  endtask

  task automatic t_fill();
    for (int r = 0; r < 16; r++) begin
      clear_req(); va = 1; vb = 1; wa = 1; wb = 1;
      for (int i = 0; i < NL; i++) begin
        act[i] = 1; ad[i] = r*32 + i; wd[i] = 32'hA000_0000 + (r*32 + i) * 7;
      end
      run("R2", 0, 0);
    end
  endtask

  task automatic t_stride1();
    clear_req(); va = 1; vb = 1;
    for (int i = 0; i < NL; i++) begin act[i] = 1; ad[i] = 64 + i; end
    run("R2", 1, 0);
  endtask

  task automatic t_broadcast();
    clear_req(); va = 1; vb = 1;
    for (int i = 0; i < NL; i++) begin act[i] = 1; ad[i] = 77; end
    run("R3", 1, 0);
  endtask

  task automatic t_cross_port();
    clear_req(); va = 1; vb = 1;
    for (int i = 0; i < NL; i++) begin act[i] = 1; ad[i] = 128 + i; end
    ad[0] = 0; ad[16] = 32;
    run("R5", 1, 0);
  endtask

  task automatic t_stride32();
    clear_req(); va = 1; vb = 0;
    for (int i = 0; i < NL; i++) begin act[i] = 1; ad[i] = i * 32; end
    ad[16] = 1;
    run("R4", 1, 0);
  endtask

  task automatic t_stride2();
    clear_req(); va = 1; vb = 1;
    for (int i = 0; i < L; i++) begin
      act[i] = 1; ad[i] = 2*i; act[i+L] = 1; ad[i+L] = 32 + 2*i;
    end
    run("R4", 1, 0);
  endtask

  task automatic t_order();
    clear_req(); va = 1;
    act[0] = 1; ad[0] = 5; act[1] = 1; ad[1] = 37; act[2] = 1; ad[2] = 5;
    run("R4", 1, 0);
  endtask

  task automatic t_port_off();
    clear_req(); va = 1; vb = 0; wb = 1;
    for (int i = 0; i < NL; i++) begin act[i] = 1; ad[i] = 200 + i; end
    for (int i = L; i < NL; i++) begin ad[i] = 300; wd[i] = 32'h0BAD_0000 + i; end
    run("R1", 1, 0);
    clear_req(); vb = 1; act[16] = 1; ad[16] = 300;
    run("R1", 1, 0);
  endtask

  task automatic t_inactive();
    clear_req(); va = 1; wa = 1;
    for (int i = 0; i < L; i++) begin ad[i] = 400 + i; wd[i] = 32'h1111_0000 + i; end
    act[0] = 1; act[1] = 1; ad[1] = 401;
    ad[5] = 432;
    run("R7", 1, 0);
    clear_req(); va = 1; act[5] = 1; ad[5] = 432; act[6] = 1; ad[6] = 406;
    run("R7", 1, 0);
    clear_req(); va = 1; vb = 1;
    run("R7", 1, 0);
  endtask

  task automatic t_collide();
    clear_req(); va = 1; vb = 1; wb = 1;
    for (int i = 0; i < L; i++) begin act[i] = 1; ad[i] = 100; end
    act[19] = 1; ad[19] = 100; wd[19] = 32'h1900_0019;
    act[25] = 1; ad[25] = 100; wd[25] = 32'h2500_0025;
    run("R9", 1, 0);
    clear_req(); va = 1; act[0] = 1; ad[0] = 100;
    run("R8", 1, 0);
  endtask

  task automatic t_stall();
    clear_req(); va = 1; vb = 1;
    for (int i = 0; i < NL; i++) begin act[i] = 1; ad[i] = 256 + i; end
    ad[20] = 288; ad[21] = 320;
    run("R6", 1, 1);
    clear_req(); va = 1; act[0] = 1; ad[0] = 7;
    run("R6", 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle_ports();
    clear_req();
    for (int i = 0; i < NL; i++) exp_rd[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_stride1();
    t_broadcast();
    t_cross_port();
    t_stride32();
    t_stride2();
    t_order();
    t_port_off();
    t_inactive();
    t_collide();
    t_stall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule